// File: doc/BRIEF.md
# Dual-Queue Priority SRAM Write Scheduler

This block sits in the memory clock domain between two request queues and a pipelined SRAM that needs no bus turnaround. Each queue presents a head word that holds a write address and its write data, together with an empty flag and an almost-empty flag. The scheduler chooses a queue, pulses that queue's read-enable, and turns the popped word into an SRAM write cycle. In that cycle the address and the write strobe are driven together. The data follows on the data bus a fixed number of cycles later, and the output enable is raised only while that data is present.

The queue flags follow a pop one cycle late. A queue samples read-enable at a clock edge, and its flags only show the effect after that edge. The scheduler allows for this lag. During a cycle in which it is popping a queue, it treats that queue's empty flag as stale. It pops the same queue again in the next cycle only if the almost-empty flag promises a second word. This lets a burst run at one write per cycle, while a queue that holds a single word is popped exactly once. The high queue has fixed priority. When the high queue cannot be popped, the low queue is served on the very next decision.

The choice is held in a three-state machine: ST_IDLE, ST_POP_HI and ST_POP_LO. The state register drives the read-enables directly. The transitions are as follows:
- ST_IDLE to ST_POP_HI when the high queue is eligible.
- ST_IDLE to ST_POP_LO when only the low queue is eligible.
- ST_POP_HI to ST_POP_HI (burst continue) when the high queue is not almost-empty.
- ST_POP_HI to ST_POP_LO (handoff) when the high queue is not eligible but the low queue is.
- ST_POP_HI to ST_IDLE when neither queue is eligible.
- ST_POP_LO to ST_POP_HI (preempt) whenever the high queue is eligible.
- ST_POP_LO to ST_POP_LO (burst continue).
- ST_POP_LO to ST_IDLE when neither queue is eligible.

A queue is eligible when it is not empty and, if it is being popped in the current cycle, it is also not almost-empty.

Top module: `dual_queue_sram_writer`

## Requirements
- R1: A queue word carries the address in its upper ADDR_W bits and the write data in its lower DATA_W bits.
- R2: At most one read-enable is high in any cycle, and a read-enable is never high while that queue's empty flag is high.
- R3: A read-enable in cycle t makes sram_we high in cycle t+1, with sram_addr equal to the address field of the word popped in cycle t. sram_we is low in every cycle not preceded by a pop.
- R4: The data field appears on sram_dq_out exactly DATA_LAG cycles (default 2) after its address cycle, with sram_dq_oe high in exactly those cycles. While sram_dq_oe is low, sram_dq_out is zero.
- R5: When both queues are eligible, the high queue is popped. A non-empty high queue that is not being popped is popped in the next cycle.
- R6: After a pop of a queue whose almost-empty flag is high, that queue gets no read-enable in the next cycle, so a single-word queue is popped exactly once.
- R7: A queue whose almost-empty flag (high when it holds fewer than two words) is low during a pop is popped again in the next cycle, so a burst of N words yields N writes in N consecutive cycles.
- R8: When the high queue stops being eligible and the low queue is waiting, the low queue is popped in the next cycle, with no idle write slot between them.
- R9: Synchronous reset clears both read-enables, sram_we, sram_dq_oe and the data pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| hi_empty | input | 1 | High-priority queue holds no word |
| hi_aempty | input | 1 | High-priority queue holds fewer than two words |
| hi_word | input | ADDR_W+DATA_W | High-priority queue head word {address, data} |
| hi_rd | output | 1 | Read-enable (pop) to the high-priority queue |
| lo_empty | input | 1 | Low-priority queue holds no word |
| lo_aempty | input | 1 | Low-priority queue holds fewer than two words |
| lo_word | input | ADDR_W+DATA_W | Low-priority queue head word {address, data} |
| lo_rd | output | 1 | Read-enable (pop) to the low-priority queue |
| sram_addr | output | ADDR_W | SRAM address bus |
| sram_we | output | 1 | SRAM write strobe |
| sram_dq_out | output | DATA_W | SRAM write data bus |
| sram_dq_oe | output | 1 | SRAM data bus output enable |

## Verification
The bench builds the block with ADDR_W=8, DATA_W=8 and DATA_LAG=2, so each scenario can give every word its own distinct address and data byte. It checks the default two-cycle data slot against a cycle counter of its own. The short queue depths this allows are enough to reach each corner case: single words, simultaneous arrivals, bursts at full rate, and a high-queue arrival that preempts a low-queue burst in progress.

// File: rtl/dqsw_pkg.sv
package dqsw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_POP_HI = 2'd1,
        ST_POP_LO = 2'd2
    } pick_state_t;

    localparam int NUM_QUEUES = 2;
    localparam int HI_IDX     = 0;
    localparam int LO_IDX     = 1;

endpackage

// File: rtl/dqsw_eligible.sv
module dqsw_eligible (
    input  logic empty,
    input  logic aempty,
    input  logic popping,
    output logic ok
);
    // The flags lag a pop by one cycle: while popping, only a second
    // guaranteed word (not almost-empty) allows another pop.
    assign ok = !empty && (!popping || !aempty);
endmodule

// File: rtl/dqsw_fsm.sv
module dqsw_fsm
    import dqsw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_QUEUES-1:0] ok,
    output logic [NUM_QUEUES-1:0] rd
);
    pick_state_t cur, nxt;

    always_ff @(posedge clk) begin
        if (rst) cur <= ST_IDLE;
        else     cur <= nxt;
    end

    always_comb begin
        nxt = ST_IDLE;
        unique case (cur)
            ST_IDLE: begin
                if      (ok[HI_IDX]) nxt = ST_POP_HI;
                else if (ok[LO_IDX]) nxt = ST_POP_LO;
                else                 nxt = ST_IDLE;
            end
            ST_POP_HI: begin
                if      (ok[HI_IDX]) nxt = ST_POP_HI;   // burst continue
                else if (ok[LO_IDX]) nxt = ST_POP_LO;   // handoff
                else                 nxt = ST_IDLE;
            end
            ST_POP_LO: begin
                if      (ok[HI_IDX]) nxt = ST_POP_HI;   // preempt
                else if (ok[LO_IDX]) nxt = ST_POP_LO;
                else                 nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        rd = '0;
        unique case (cur)
            ST_IDLE:   rd = '0;
            ST_POP_HI: rd[HI_IDX] = 1'b1;
            ST_POP_LO: rd[LO_IDX] = 1'b1;
            default:   rd = '0;
        endcase
    end
endmodule

// File: rtl/dqsw_delay.sv
module dqsw_delay #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [WIDTH-1:0] in_dat,
    output logic             out_vld,
    output logic [WIDTH-1:0] out_dat
);
    logic             vld_q [DEPTH];
    logic [WIDTH-1:0] dat_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[s] <= 1'b0;
                dat_q[s] <= '0;
            end else if (s == 0) begin
                vld_q[s] <= in_vld;
                dat_q[s] <= in_dat;
            end else begin
                vld_q[s] <= vld_q[(s == 0) ? 0 : s-1];
                dat_q[s] <= dat_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign out_vld = vld_q[DEPTH-1];
    assign out_dat = dat_q[DEPTH-1];
endmodule

// File: rtl/dual_queue_sram_writer.sv
module dual_queue_sram_writer
    import dqsw_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 16,
    parameter int DATA_LAG = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     hi_empty,
    input  logic                     hi_aempty,
    input  logic [ADDR_W+DATA_W-1:0] hi_word,
    output logic                     hi_rd,
    input  logic                     lo_empty,
    input  logic                     lo_aempty,
    input  logic [ADDR_W+DATA_W-1:0] lo_word,
    output logic                     lo_rd,
    output logic [ADDR_W-1:0]        sram_addr,
    output logic                     sram_we,
    output logic [DATA_W-1:0]        sram_dq_out,
    output logic                     sram_dq_oe
);
    localparam int WORD_W = ADDR_W + DATA_W;

    logic [NUM_QUEUES-1:0] q_empty, q_aempty, q_ok, q_rd;
    logic [WORD_W-1:0]     q_word [NUM_QUEUES];

    assign q_empty  = {lo_empty,  hi_empty};
    assign q_aempty = {lo_aempty, hi_aempty};
    assign q_word[HI_IDX] = hi_word;
    assign q_word[LO_IDX] = lo_word;

    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_elig
        dqsw_eligible u_elig (
            .empty   (q_empty[q]),
            .aempty  (q_aempty[q]),
            .popping (q_rd[q]),
            .ok      (q_ok[q])
        );
    end

    dqsw_fsm u_fsm (
        .clk (clk),
        .rst (rst),
        .ok  (q_ok),
        .rd  (q_rd)
    );

    assign hi_rd = q_rd[HI_IDX];
    assign lo_rd = q_rd[LO_IDX];

    // Address stage: the head word popped this cycle is captured at the edge.
    logic [DATA_W-1:0] wdata_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sram_we   <= 1'b0;
            sram_addr <= '0;
            wdata_s   <= '0;
        end else begin
            sram_we <= |q_rd;
            if (q_rd[HI_IDX]) begin
                sram_addr <= q_word[HI_IDX][WORD_W-1 -: ADDR_W];
                wdata_s   <= q_word[HI_IDX][DATA_W-1:0];
            end else if (q_rd[LO_IDX]) begin
                sram_addr <= q_word[LO_IDX][WORD_W-1 -: ADDR_W];
                wdata_s   <= q_word[LO_IDX][DATA_W-1:0];
            end
        end
    end

    logic              dly_vld;
    logic [DATA_W-1:0] dly_dat;

    dqsw_delay #(
        .WIDTH (DATA_W),
        .DEPTH (DATA_LAG)
    ) u_delay (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (sram_we),
        .in_dat  (wdata_s),
        .out_vld (dly_vld),
        .out_dat (dly_dat)
    );

    assign sram_dq_oe  = dly_vld;
    assign sram_dq_out = dly_vld ? dly_dat : '0;
endmodule

// File: rtl/dqsw_checker.sv
module dqsw_checker #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 16,
    parameter int DATA_LAG = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              hi_empty,
    input logic              hi_aempty,
    input logic [ADDR_W-1:0] hi_addr,
    input logic              hi_rd,
    input logic              lo_empty,
    input logic              lo_aempty,
    input logic [ADDR_W-1:0] lo_addr,
    input logic              lo_rd,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_we,
    input logic [DATA_W-1:0] sram_dq_out,
    input logic              sram_dq_oe
);
    logic [DATA_LAG-1:0] we_hist;

    always_ff @(posedge clk) begin
        if (rst) we_hist <= '0;
        else     we_hist <= (we_hist << 1) | DATA_LAG'(sram_we);
    end

    assert_single_rd_R2: assert property (@(posedge clk) disable iff (rst)
        !(hi_rd && lo_rd));
    assert_hi_not_empty_R2: assert property (@(posedge clk) disable iff (rst)
        hi_rd |-> !hi_empty);
    assert_lo_not_empty_R2: assert property (@(posedge clk) disable iff (rst)
        lo_rd |-> !lo_empty);
    assert_strobe_after_pop_R3: assert property (@(posedge clk) disable iff (rst)
        (hi_rd || lo_rd) |=> sram_we);
    assert_strobe_only_after_pop_R3: assert property (@(posedge clk) disable iff (rst)
        sram_we |-> $past(hi_rd || lo_rd));
    assert_hi_addr_R1: assert property (@(posedge clk) disable iff (rst)
        hi_rd |=> sram_addr == $past(hi_addr));
    assert_lo_addr_R1: assert property (@(posedge clk) disable iff (rst)
        lo_rd |=> sram_addr == $past(lo_addr));
    assert_data_slot_R4: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe == we_hist[DATA_LAG-1]);
    assert_bus_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
        !sram_dq_oe |-> sram_dq_out == '0);
    assert_priority_R5: assert property (@(posedge clk) disable iff (rst)
        (!hi_empty && !hi_rd) |=> hi_rd);
    assert_hi_single_pop_R6: assert property (@(posedge clk) disable iff (rst)
        (hi_rd && hi_aempty) |=> !hi_rd);
    assert_lo_single_pop_R6: assert property (@(posedge clk) disable iff (rst)
        (lo_rd && lo_aempty) |=> !lo_rd);
    assert_hi_burst_R7: assert property (@(posedge clk) disable iff (rst)
        (hi_rd && !hi_aempty) |=> hi_rd);
    assert_handoff_R8: assert property (@(posedge clk) disable iff (rst)
        (hi_empty && !hi_rd && !lo_empty && !lo_rd) |=> lo_rd);
    assert_reset_clear_R9: assert property (@(posedge clk)
        $past(rst) |-> (!hi_rd && !lo_rd && !sram_we && !sram_dq_oe));
endmodule

bind dual_queue_sram_writer dqsw_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .DATA_LAG (DATA_LAG)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hi_empty    (hi_empty),
    .hi_aempty   (hi_aempty),
    .hi_addr     (hi_word[ADDR_W+DATA_W-1 -: ADDR_W]),
    .hi_rd       (hi_rd),
    .lo_empty    (lo_empty),
    .lo_aempty   (lo_aempty),
    .lo_addr     (lo_word[ADDR_W+DATA_W-1 -: ADDR_W]),
    .lo_rd       (lo_rd),
    .sram_addr   (sram_addr),
    .sram_we     (sram_we),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe)
);

// File: tb/dual_queue_sram_writer_test.sv
module dual_queue_sram_writer_test;
    localparam int AW = 8, DW = 8, LAG = 2, WW = AW + DW, QD = 64;

    logic clk = 1'b0, rst = 1'b1;
    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Behavioural queues on the memory clock: tail moves from tasks, head on pops.
    logic [WW-1:0] mem0 [QD];
    logic [WW-1:0] mem1 [QD];
    int head0 = 0, tail0 = 0, head1 = 0, tail1 = 0;
    int pops0 = 0, pops1 = 0, bad_pops = 0;

    logic hi_empty, hi_aempty, lo_empty, lo_aempty, hi_rd, lo_rd;
    logic [WW-1:0] hi_word, lo_word;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_dq_out;
    logic sram_we, sram_dq_oe;

    assign hi_empty  = (tail0 - head0) == 0;
    assign hi_aempty = (tail0 - head0) < 2;
    assign hi_word   = mem0[head0 % QD];
    assign lo_empty  = (tail1 - head1) == 0;
    assign lo_aempty = (tail1 - head1) < 2;
    assign lo_word   = mem1[head1 % QD];

    always @(posedge clk) begin
        if (hi_rd) begin
            if (tail0 == head0) bad_pops <= bad_pops + 1;
            else head0 <= head0 + 1;
            pops0 <= pops0 + 1;
        end
        if (lo_rd) begin
            if (tail1 == head1) bad_pops <= bad_pops + 1;
            else head1 <= head1 + 1;
            pops1 <= pops1 + 1;
        end
    end

    dual_queue_sram_writer #(.ADDR_W(AW), .DATA_W(DW), .DATA_LAG(LAG)) uut (
        .clk(clk), .rst(rst),
        .hi_empty(hi_empty), .hi_aempty(hi_aempty), .hi_word(hi_word), .hi_rd(hi_rd),
        .lo_empty(lo_empty), .lo_aempty(lo_aempty), .lo_word(lo_word), .lo_rd(lo_rd),
        .sram_addr(sram_addr), .sram_we(sram_we),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe)
    );

    int checks = 0, failures = 0;
    bit done = 1'b0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Scoreboard
    logic [WW-1:0] exp_q [$];
    logic [DW-1:0] dexp [$];
    int            ddue [$];
    int            we_log [$];
    logic          prev_rd = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            check(sram_we == prev_rd, "R3", "strobe one cycle after pop", int'(sram_we), int'(prev_rd));
            check(!(hi_rd && lo_rd), "R2", "both read-enables high", int'(hi_rd) + int'(lo_rd), 1);
            if (sram_we) begin
                we_log.push_back(cyc);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected write address", int'(sram_addr), -1);
                end else begin
                    logic [WW-1:0] w;
                    w = exp_q.pop_front();
                    check(sram_addr == w[WW-1 -: AW], "R1", "write address order", int'(sram_addr), int'(w[WW-1 -: AW]));
                    dexp.push_back(w[DW-1:0]);
                    ddue.push_back(cyc + LAG);
                end
            end
            if (sram_dq_oe) begin
                if (dexp.size() == 0) begin
                    check(1'b0, "R4", "unexpected data slot", int'(sram_dq_out), -1);
                end else begin
                    logic [DW-1:0] d;
                    int due;
                    d = dexp.pop_front();
                    due = ddue.pop_front();
                    check(sram_dq_out == d, "R4", "write data value", int'(sram_dq_out), int'(d));
                    check(cyc == due, "R4", "write data cycle", cyc, due);
                end
            end else begin
                check(sram_dq_out == '0, "R4", "bus value while disabled", int'(sram_dq_out), 0);
            end
            prev_rd = hi_rd || lo_rd;
        end
    end

    // Driver: place n words into a queue at a negedge; optionally expect them in order.
    task automatic load(int qi, int n, int base, bit expect_now);
        for (int i = 0; i < n; i++) begin
            logic [WW-1:0] w;
            w = {AW'(base + i), DW'((base + i) * 7 + 13)};
            if (qi == 0) begin mem0[tail0 % QD] = w; tail0 = tail0 + 1; end
            else         begin mem1[tail1 % QD] = w; tail1 = tail1 + 1; end
            if (expect_now) exp_q.push_back(w);
        end
    endtask

    function automatic logic [WW-1:0] mkw(int a);
        return {AW'(a), DW'(a * 7 + 13)};
    endfunction

    task automatic drain();
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (hi_empty && lo_empty && exp_q.size() == 0 && dexp.size() == 0 && !sram_we) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_span(int first_idx, int n, string req);
        check(we_log.size() == first_idx + n, req, "write count", we_log.size() - first_idx, n);
        if (we_log.size() == first_idx + n)
            check(we_log[first_idx + n - 1] - we_log[first_idx] == n - 1, req,
                  "consecutive write slots", we_log[first_idx + n - 1] - we_log[first_idx], n - 1);
    endtask

    initial begin
        int p0, p1, base;
        repeat (4) @(negedge clk);
        check(!hi_rd && !lo_rd && !sram_we && !sram_dq_oe, "R9", "outputs during reset",
              int'(hi_rd) + int'(lo_rd) + int'(sram_we) + int'(sram_dq_oe), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R6: single word in the high queue, popped once
        p0 = pops0; base = we_log.size();
        load(0, 1, 8'h10, 1'b1);
        drain();
        check(pops0 - p0 == 1, "R6", "pops of single high word", pops0 - p0, 1);
        check_span(base, 1, "R6");

        // R6: single word in the low queue
        p1 = pops1; base = we_log.size();
        load(1, 1, 8'h20, 1'b1);
        drain();
        check(pops1 - p1 == 1, "R6", "pops of single low word", pops1 - p1, 1);

        // R5/R8: simultaneous single words, high first then low with no gap
        p0 = pops0; p1 = pops1; base = we_log.size();
        load(0, 1, 8'h30, 1'b1);
        load(1, 1, 8'h40, 1'b1);
        drain();
        check_span(base, 2, "R8");
        check(pops0 - p0 == 1 && pops1 - p1 == 1, "R6", "one pop each", pops0 - p0 + pops1 - p1, 2);

        // R7: high burst at full rate
        base = we_log.size();
        load(0, 5, 8'h50, 1'b1);
        drain();
        check_span(base, 5, "R7");

        // R7: low burst at full rate
        base = we_log.size();
        load(1, 4, 8'h60, 1'b1);
        drain();
        check_span(base, 4, "R7");

        // R5/R8: simultaneous bursts, all high words then all low words, back to back
        base = we_log.size();
        load(0, 3, 8'h70, 1'b1);
        load(1, 3, 8'h80, 1'b1);
        drain();
        check_span(base, 6, "R5");

        // R5: high words arrive during a low burst and preempt it
        base = we_log.size();
        load(1, 4, 8'hA0, 1'b0);
        repeat (2) @(negedge clk);
        load(0, 2, 8'hC0, 1'b0);
        exp_q.push_back(mkw(8'hA0));
        exp_q.push_back(mkw(8'hA1));
        exp_q.push_back(mkw(8'hC0));
        exp_q.push_back(mkw(8'hC1));
        exp_q.push_back(mkw(8'hA2));
        exp_q.push_back(mkw(8'hA3));
        drain();
        check_span(base, 6, "R5");

        // R9: reset in the middle of a burst clears the strobe and data pipeline
        load(0, 3, 8'hE0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!hi_rd && !lo_rd && !sram_we && !sram_dq_oe, "R9", "outputs after mid-burst reset",
              int'(hi_rd) + int'(lo_rd) + int'(sram_we) + int'(sram_dq_oe), 0);
        head0 = tail0;
        exp_q.delete(); dexp.delete(); ddue.delete();
        prev_rd = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(!sram_we && !sram_dq_oe, "R9", "idle after reset", int'(sram_we) + int'(sram_dq_oe), 0);

        check(bad_pops == 0, "R2", "pops of an empty queue", bad_pops, 0);
        check(exp_q.size() == 0, "R3", "addresses never written", exp_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule